// File: doc/BRIEF.md
# Segmented-Counter Clock-Enable Generator

This block lets slow logic run on the fast master clock. Instead of dividing the clock, it produces a single-cycle enable pulse once every PERIOD master-clock cycles. Downstream registers stay on the master clock and update only in cycles where that enable is high. The divide ratio is fixed when the block is built. The block has no runtime control beyond a synchronous reset.

The count is held as a down-counter that is cut into sections of SEG_W bits. Each section keeps a registered flag that is set when the section holds zero. The borrow into a section is formed from the flags of the sections below it, not from their full values. The final terminal state is found one cycle early, from the low section reading one and every upper flag being set, and is captured in a single flip-flop. The counter reloads PERIOD-1 from that flip-flop. A second flip-flop drives the output pulse, so no wide decode lies between any register and the enable. WIDTH need not be a multiple of SEG_W. The top section is then padded.

Top module: `segcnt_tick`

## Requirements
- R1: `tick` is never high in two consecutive cycles; each pulse lasts exactly one master-clock cycle.
- R2: Two consecutive pulses of `tick` are exactly PERIOD master-clock cycles apart, with no drift over many periods.
- R3: After reset is released, `tick` stays low for the first PERIOD-1 rising edges with reset low. It is high in the cycle that follows the PERIOD-th such edge.
- R4: Reset is synchronous and active high. While it is sampled high, `tick` is low. A reset applied in mid-period restarts the timing of R3.
- R5: With PERIOD = 2 the enable alternates high and low on every cycle.
- R6: A PERIOD that fits entirely within the low section (PERIOD ≤ 2^SEG_W) works correctly. This includes a build where the whole counter is one section (SEG_W = WIDTH).
- R7: A PERIOD whose reload value PERIOD-1 has an all-zero low section works correctly. Every borrow is then taken from an upper section (for example 17 with SEG_W=4, or 257 and 65537 with SEG_W=8).
- R8: The largest ratio, PERIOD = 2^WIDTH, works correctly. This holds when WIDTH is not a multiple of SEG_W.
- R9: Over any run of C cycles counted from reset release, the number of pulses is exactly floor(C / PERIOD).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick | output | 1 | Registered enable, high for one cycle out of every PERIOD |

## Verification
The enable is due exactly PERIOD rising edges after reset release, and again every PERIOD edges after that. The internal terminal flip-flop leads it by one edge. All inputs change on the falling edge. Every output is sampled 5 ns after a rising edge, so each count of edges matches the cycle in which the output register has settled. Per-instance monitors count edges from the release of reset for nine divide ratios and section layouts at once. The bench compares the first pulse position, every gap, the pulse width and the total pulse count with values computed from PERIOD alone. A directed instance also checks quiet output during reset and the restart after a reset in mid-period.

// File: rtl/segcnt_pkg.sv
package segcnt_pkg;

    // Status that one counter section reports to its neighbours.
    typedef struct packed {
        logic zero;   // registered: section currently holds zero
        logic one;    // section currently holds one
    } seg_flag_t;

    // Number of sections needed to cover a counter of the given width.
    function automatic int seg_count(input int width, input int seg_w);
        return (width + seg_w - 1) / seg_w;
    endfunction

    // Padded counter width after splitting into whole sections.
    function automatic int padded_width(input int width, input int seg_w);
        return seg_count(width, seg_w) * seg_w;
    endfunction

endpackage

// File: rtl/segcnt_section.sv
module segcnt_section
    import segcnt_pkg::*;
#(
    parameter int               SEG_W    = 8,
    parameter logic [SEG_W-1:0] LOAD_VAL = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,   // full counter reload
    input  logic      step_i,   // decrement this section
    output seg_flag_t flags_o
);

    logic [SEG_W-1:0] val_q;
    logic             zero_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            val_q  <= LOAD_VAL;
            zero_q <= (LOAD_VAL == '0);
        end else if (step_i) begin
            val_q  <= val_q - SEG_W'(1);
            zero_q <= (val_q == SEG_W'(1));
        end
    end

    always_comb begin
        flags_o.zero = zero_q;
        flags_o.one  = (val_q == SEG_W'(1));
    end

endmodule

// File: rtl/segcnt_final.sv
module segcnt_final (
    input  logic clk,
    input  logic rst,
    input  logic low_one_i,     // low section holds one
    input  logic high_zero_i,   // every upper section flag set
    output logic term_o,        // counter currently at zero
    output logic tick_o
);

    logic term_q;
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            term_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            term_q <= !term_q && low_one_i && high_zero_i;
            tick_q <= term_q;
        end
    end

    assign term_o = term_q;
    assign tick_o = tick_q;

endmodule

// File: rtl/segcnt_tick.sv
module segcnt_tick
    import segcnt_pkg::*;
#(
    parameter int          WIDTH  = 24,
    parameter int          SEG_W  = 8,
    parameter int unsigned PERIOD = 2500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int              NSEG     = seg_count(WIDTH, SEG_W);
    localparam int              PADW     = padded_width(WIDTH, SEG_W);
    localparam logic [PADW-1:0] RELOAD_V = PADW'(PERIOD - 1);

    seg_flag_t       flg [NSEG];
    logic [NSEG-1:0] zero_v;
    logic [NSEG-1:0] one_v;
    logic [NSEG-1:0] step_v;
    logic            term;
    logic            high_zero;

    assign step_v[0] = !term;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        segcnt_section #(
            .SEG_W    (SEG_W),
            .LOAD_VAL (RELOAD_V[i*SEG_W +: SEG_W])
        ) u_sec (
            .clk     (clk),
            .rst     (rst),
            .load_i  (term),
            .step_i  (step_v[i]),
            .flags_o (flg[i])
        );
        assign zero_v[i] = flg[i].zero;
        assign one_v[i]  = flg[i].one;
        if (i > 0) begin : g_borrow
            assign step_v[i] = step_v[i-1] && zero_v[i-1];
        end
    end

    if (NSEG == 1) begin : g_single
        assign high_zero = 1'b1;
    end else begin : g_multi
        assign high_zero = &zero_v[NSEG-1:1];
    end

    segcnt_final u_final (
        .clk         (clk),
        .rst         (rst),
        .low_one_i   (one_v[0]),
        .high_zero_i (high_zero),
        .term_o      (term),
        .tick_o      (tick)
    );

endmodule

// File: rtl/segcnt_tick_chk.sv
module segcnt_tick_chk #(
    parameter int          NSEG   = 3,
    parameter int unsigned PERIOD = 2500
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic            term,
    input logic [NSEG-1:0] zero_v,
    input logic [NSEG-1:0] one_v
);

    logic [31:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) gap_q <= '0;
        else     gap_q <= tick ? 32'd1 : gap_q + 32'd1;
    end

    AST_ONE_CYCLE_TICK: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                              // R1
    AST_TERM_SHORT: assert property (@(posedge clk) disable iff (rst)
        term |=> !term);                                              // R1
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == PERIOD));                                  // R2
    AST_NO_LATE_TICK: assert property (@(posedge clk) disable iff (rst)
        (gap_q == PERIOD) |-> tick);                                  // R3
    AST_TERM_FLAGS: assert property (@(posedge clk) disable iff (rst)
        term |-> (&zero_v));                                          // R2

    for (genvar i = 0; i < NSEG; i++) begin : g_flag
        AST_FLAG_STEP: assert property (@(posedge clk) disable iff (rst)
            ($rose(zero_v[i]) && !$past(term)) |-> $past(one_v[i])); // R7
    end

endmodule

bind segcnt_tick segcnt_tick_chk #(
    .NSEG   (NSEG),
    .PERIOD (PERIOD)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .term   (term),
    .zero_v (zero_v),
    .one_v  (one_v)
);

// File: tb/segcnt_tick_tb.sv
`timescale 1ns/1ps
module segcnt_tick_tb;

    localparam int NROWS = 9;
    localparam int RUN   = 135000;
    localparam int DN    = 301;
    // table: width, section width, period
    localparam int ROW_W [NROWS] = '{24, 24, 24,  24,   24,   10, 10, 12, 24};
    localparam int ROW_S [NROWS] = '{ 8,  8,  8,   8,    8,    4,  4, 12,  8};
    localparam int ROW_N [NROWS] = '{ 2,  3, 256, 257, 1000, 1024, 17,  5, 65537};

    logic clk = 1'b0;
    logic rst_d = 1'b1;
    logic rst_t = 1'b1;
    logic tick_d;
    bit   freeze = 1'b0;
    int   checks = 0;
    int   fails  = 0;

    int first_a  [NROWS] = '{default: 0};
    int pulses_a [NROWS] = '{default: 0};
    int gaperr_a [NROWS] = '{default: 0};
    int widerr_a [NROWS] = '{default: 0};
    int rsterr_a [NROWS] = '{default: 0};
    int cyc_a    [NROWS] = '{default: 0};
    string row_req [NROWS] = '{"R5", "R2", "R6", "R7", "R2", "R8", "R7", "R6", "R7"};

    always #10 clk = ~clk;

    segcnt_tick #(.WIDTH(24), .SEG_W(8), .PERIOD(DN)) u_dut (
        .clk (clk), .rst (rst_d), .tick (tick_d));

    for (genvar k = 0; k < NROWS; k++) begin : g_row
        logic tk;
        int   cyc  = 0;
        int   last = 0;
        bit   prev = 1'b0;
        segcnt_tick #(.WIDTH(ROW_W[k]), .SEG_W(ROW_S[k]), .PERIOD(ROW_N[k])) u_dut (
            .clk (clk), .rst (rst_t), .tick (tk));
        always @(posedge clk) begin
            #5;
            if (!freeze) begin
                if (rst_t) begin
                    cyc  = 0;
                    prev = 1'b0;
                    if (tk) rsterr_a[k]++;
                end else begin
                    cyc++;
                    if (tk) begin
                        if (prev) widerr_a[k]++;
                        if (pulses_a[k] == 0) first_a[k] = cyc;
                        else if (cyc - last != ROW_N[k]) gaperr_a[k]++;
                        last = cyc;
                        pulses_a[k]++;
                    end
                    prev     = tk;
                    cyc_a[k] = cyc;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #5;
            n++;
        end while (!tick_d && n < 100000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R4: quiet during reset
        repeat (3) begin
            @(posedge clk); #5;
            check(tick_d == 1'b0, "R4 tick low in reset", tick_d, 0);
        end
        @(negedge clk) rst_d = 1'b0;
        wait_tick(n);
        check(n == DN, "R3 first pulse position", n, DN);
        @(posedge clk); #5;
        check(tick_d == 1'b0, "R1 pulse width one cycle", tick_d, 0);
        wait_tick(n);
        check(n + 1 == DN, "R2 second gap", n + 1, DN);
        for (int p = 0; p < 3; p++) begin
            wait_tick(n);
            check(n == DN, "R2 steady gap", n, DN);
        end
        // R4: reset in mid-period restarts timing
        repeat (100) @(posedge clk);
        @(negedge clk) rst_d = 1'b1;
        repeat (2) begin
            @(posedge clk); #5;
            check(tick_d == 1'b0, "R4 tick low in mid-run reset", tick_d, 0);
        end
        @(negedge clk) rst_d = 1'b0;
        wait_tick(n);
        check(n == DN, "R4 restart first pulse", n, DN);

        // table of ratios and layouts, run together
        @(negedge clk) rst_t = 1'b0;
        repeat (RUN) @(posedge clk);
        @(negedge clk) freeze = 1'b1;
        for (int k = 0; k < NROWS; k++) begin
            check(rsterr_a[k] == 0, "R4 table tick in reset", rsterr_a[k], 0);
            check(widerr_a[k] == 0, "R1 table width", widerr_a[k], 0);
            check(gaperr_a[k] == 0, "R2 table gaps", gaperr_a[k], 0);
            check(first_a[k] == ROW_N[k], "R3 table first pulse", first_a[k], ROW_N[k]);
            check(pulses_a[k] == cyc_a[k] / ROW_N[k], "R9 table pulse count",
                  pulses_a[k], cyc_a[k] / ROW_N[k]);
            check(pulses_a[k] > 0 && gaperr_a[k] == 0 && first_a[k] == ROW_N[k],
                  {row_req[k], " row ratio"}, first_a[k], ROW_N[k]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule